// File: doc/BRIEF.md
# Ten-port packet switching router

This block is one switching node of a mesh on-chip network. It has ten bidirectional 8-bit ports, and each port carries an end-of-packet sideband bit. Every input has a four-flit queue that takes flits from the neighbouring node whenever the queue has room. The first flit of each packet is a header. Its low four bits name the output port the packet leaves on.

Each output has its own round-robin arbiter. The arbiter picks one of the queues that want that output and locks the grant for the whole packet. While the grant is held, the output's 10:1 multiplexer forwards that queue's head flits. The grant is released when the flit carrying the end-of-packet bit leaves. The output is then offered to the waiting inputs in rotating order, starting just after the last winner. A header that names a port outside 0 to 9 makes the whole packet be discarded.

Top module: `noc_router10`

## Requirements
- R1: After a synchronous active-high reset, every `out_valid` bit is low, every `in_ready` bit is high, and every arbiter's rotation starts at input 0.
- R2: A packet's first flit is a header whose bits [3:0] give the destination output 0 to 9. Every flit of the packet appears unchanged, in order, on that output alone, for every pairing of input and output. The end-of-packet bit stays aligned with its flit.
- R3: Each input queue holds 4 flits, and `in_ready` equals not-full. A flit is taken only in a cycle where `in_valid` and `in_ready` are both high, and no flit is lost while the output is stalled.
- R4: Once an output is granted to an input, it carries only that input's flits until the flit with `last` set has been accepted. Packets never interleave on an output.
- R5: When several inputs contend for one output, the next grant goes to the first requesting input at or after the position just past the previous winner, wrapping from 9 to 0.
- R6: A packet whose header bits [3:0] hold 10 to 15 is discarded up to and including its last flit. Nothing of it appears on any output, and the next packet from the same input is delivered normally.
- R7: An output with no granted, non-empty input keeps `out_valid` low. A flit leaves an output only when `out_ready` is high, and while `out_valid` is high and `out_ready` is low the flit on the output holds steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 10 | Per-input flit valid |
| in_data | input | 80 | Per-input flit, 8 bits per port, port p at bits [8p+7:8p] |
| in_last | input | 10 | Per-input end-of-packet marker |
| in_ready | output | 10 | Per-input queue not full |
| out_valid | output | 10 | Per-output flit valid |
| out_data | output | 80 | Per-output flit, 8 bits per port, port p at bits [8p+7:8p] |
| out_last | output | 10 | Per-output end-of-packet marker |
| out_ready | input | 10 | Per-output downstream ready |

## Verification
The assertions take two things for granted about the neighbours. First, upstream senders present a header as the first flit of every packet. Second, every packet ends with a flit marked `last`, so a locked grant is always eventually released. The stimulus keeps to this by building every packet in one driver task, which sets `last` only on the final flit. That task also holds each flit until the queue shows room, so no flit is offered again after it has been accepted. Downstream ready is changed only between rounds, or while a single stalled packet is being watched, so the stall-stability property sees a ready that is settled.

// File: rtl/noc_router10.sv
module noc_router10 #(
  parameter int NPORTS = 10,
  parameter int DW     = 8,
  parameter int DEPTH  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPORTS-1:0]    in_valid,
  input  logic [NPORTS*DW-1:0] in_data,
  input  logic [NPORTS-1:0]    in_last,
  output logic [NPORTS-1:0]    in_ready,
  output logic [NPORTS-1:0]    out_valid,
  output logic [NPORTS*DW-1:0] out_data,
  output logic [NPORTS-1:0]    out_last,
  input  logic [NPORTS-1:0]    out_ready
);
  localparam int PW = $clog2(NPORTS);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW:0]        mem     [NPORTS][DEPTH];
  logic [AW-1:0]      rd_q    [NPORTS];
  logic [AW-1:0]      wr_q    [NPORTS];
  logic [CW-1:0]      cnt_q   [NPORTS];
  logic [PW-1:0]      dest_q  [NPORTS];
  logic [NPORTS-1:0]  in_pkt_q, drop_q;
  logic [NPORTS-1:0]  lock_q;
  logic [PW-1:0]      owner_q [NPORTS];
  logic [PW-1:0]      ptr_q   [NPORTS];

  logic [DW:0]        head    [NPORTS];
  logic [PW-1:0]      hdr_dest[NPORTS];
  logic [PW-1:0]      cur_dest[NPORTS];
  logic [NPORTS-1:0]  empty, full, wr, hdr_bad, drop_pop, pop;
  logic [NPORTS-1:0]  req     [NPORTS];
  logic [NPORTS-1:0]  own     [NPORTS];
  logic [NPORTS-1:0]  gnt_any, fwd_pop;
  logic [PW-1:0]      gnt_idx [NPORTS];

  always_comb begin
    for (int i = 0; i < NPORTS; i++) begin
      empty[i]    = (cnt_q[i] == '0);
      full[i]     = (cnt_q[i] == CW'(DEPTH));
      wr[i]       = in_valid[i] && !full[i];
      head[i]     = mem[i][rd_q[i]];
      hdr_dest[i] = head[i][PW-1:0];
      hdr_bad[i]  = !in_pkt_q[i] && (hdr_dest[i] >= PW'(NPORTS));
      cur_dest[i] = in_pkt_q[i] ? dest_q[i] : hdr_dest[i];
      drop_pop[i] = !empty[i] && (drop_q[i] || hdr_bad[i]);
    end
  end

  assign in_ready = ~full;

  always_comb begin
    for (int o = 0; o < NPORTS; o++)
      for (int i = 0; i < NPORTS; i++) begin
        req[o][i] = !empty[i] && !drop_q[i] && !hdr_bad[i] && (cur_dest[i] == PW'(o));
        own[i][o] = lock_q[o] && (owner_q[o] == PW'(i));
      end
  end

  always_comb begin
    int idx;
    for (int o = 0; o < NPORTS; o++) begin
      gnt_any[o] = 1'b0;
      gnt_idx[o] = '0;
      for (int k = 0; k < NPORTS; k++) begin
        idx = int'(ptr_q[o]) + k;
        if (idx >= NPORTS) idx = idx - NPORTS;
        if (!gnt_any[o] && req[o][idx]) begin
          gnt_any[o] = 1'b1;
          gnt_idx[o] = PW'(idx);
        end
      end
    end
  end

  always_comb begin
    pop = drop_pop;
    for (int o = 0; o < NPORTS; o++) begin
      out_valid[o]         = lock_q[o] && !empty[owner_q[o]];
      out_data[o*DW +: DW] = head[owner_q[o]][DW-1:0];
      out_last[o]          = head[owner_q[o]][DW];
      fwd_pop[o]           = out_valid[o] && out_ready[o];
      if (fwd_pop[o]) pop[owner_q[o]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPORTS; i++) begin
      if (wr[i]) mem[i][wr_q[i]] <= {in_last[i], in_data[i*DW +: DW]};
      if (rst) begin
        rd_q[i]     <= '0;
        wr_q[i]     <= '0;
        cnt_q[i]    <= '0;
        dest_q[i]   <= '0;
        in_pkt_q[i] <= 1'b0;
        drop_q[i]   <= 1'b0;
      end else begin
        if (wr[i])  wr_q[i] <= (wr_q[i] == AW'(DEPTH-1)) ? '0 : wr_q[i] + 1'b1;
        if (pop[i]) rd_q[i] <= (rd_q[i] == AW'(DEPTH-1)) ? '0 : rd_q[i] + 1'b1;
        cnt_q[i] <= cnt_q[i] + CW'(wr[i]) - CW'(pop[i]);
        if (pop[i]) begin
          if (head[i][DW]) begin
            in_pkt_q[i] <= 1'b0;
            drop_q[i]   <= 1'b0;
          end else if (!in_pkt_q[i]) begin
            in_pkt_q[i] <= 1'b1;
            drop_q[i]   <= hdr_bad[i];
            dest_q[i]   <= hdr_dest[i];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int o = 0; o < NPORTS; o++) begin
      if (rst) begin
        lock_q[o]  <= 1'b0;
        owner_q[o] <= '0;
        ptr_q[o]   <= '0;
      end else if (!lock_q[o]) begin
        if (gnt_any[o]) begin
          lock_q[o]  <= 1'b1;
          owner_q[o] <= gnt_idx[o];
          ptr_q[o]   <= (gnt_idx[o] == PW'(NPORTS-1)) ? '0 : gnt_idx[o] + 1'b1;
        end
      end else if (fwd_pop[o] && out_last[o]) begin
        lock_q[o] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      cnt_q[g] <= CW'(DEPTH)); // R3
    AST_ONE_OUTPUT_PER_INPUT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(own[g])); // R4
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
      lock_q[g] && !(fwd_pop[g] && out_last[g]) |=> lock_q[g] && $stable(owner_q[g])); // R4
    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
      out_valid[g] && !out_ready[g] |=> out_valid[g] && $stable(out_data[g*DW +: DW])); // R7
  end
endmodule

// File: tb/noc_router10_tb_top.sv
`timescale 1ns/1ps
module noc_router10_tb_top;
  localparam int N = 10;
  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0]   in_valid, in_last, in_ready, out_valid, out_last, out_ready;
  logic [N*8-1:0] in_data, out_data;
  logic           drv_v [N];
  logic           drv_l [N];
  logic [7:0]     drv_d [N];
  logic [8:0]     rec   [N][48];
  int             rec_n [N];
  int checks = 0, errors = 0, busy = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always_comb
    for (int p = 0; p < N; p++) begin
      in_valid[p]       = drv_v[p];
      in_last[p]        = drv_l[p];
      in_data[p*8 +: 8] = drv_d[p];
    end

  noc_router10 dut_i (.clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_ready(out_ready));

  initial forever begin
    @(negedge clk); #1;
    for (int o = 0; o < N; o++)
      if (!rst && out_valid[o] && out_ready[o] && rec_n[o] < 48) begin
        rec[o][rec_n[o]] = {out_last[o], out_data[o*8 +: 8]};
        rec_n[o]++;
      end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] flit(int src, int lo, int k, int len);
    return {k == len-1, 4'(src), (k == 0) ? 4'(lo) : 4'(k)};
  endfunction

  task automatic send_pkt(input int p, input int lo, input int len);
    bit taken;
    busy++;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      {drv_l[p], drv_d[p]} = flit(p, lo, k, len);
      drv_v[p] = 1'b1;
      taken = 0;
      while (!taken) begin
        taken = in_ready[p];
        @(posedge clk);
        if (!taken) @(negedge clk);
      end
    end
    @(negedge clk);
    drv_v[p] = 1'b0;
    busy--;
  endtask

  task automatic clear_rec();
    for (int o = 0; o < N; o++) rec_n[o] = 0;
  endtask

  task automatic settle(input int cyc);
    wait (busy == 0);
    repeat (cyc) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
  endtask

  task automatic check_pkt(input int o, input int base, input int src, input int lo,
                           input int len, input string tag);
    for (int k = 0; k < len; k++)
      chk(rec[o][base+k] == flit(src, lo, k, len), tag, rec[o][base+k], flit(src, lo, k, len));
  endtask

  initial begin
    for (int p = 0; p < N; p++) begin drv_v[p] = 0; drv_l[p] = 0; drv_d[p] = 0; end
    out_ready = '1;
    clear_rec();
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == '0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == '1, "R1 in_ready after reset", in_ready, 10'h3ff);
    rst = 1'b0;

    // R2: every input to every output, ten shifted permutations
    for (int sh = 0; sh < N; sh++) begin
      clear_rec();
      for (int s = 0; s < N; s++) begin
        automatic int ss = s;
        automatic int dd = (s + sh) % N;
        fork send_pkt(ss, dd, 3); join_none
      end
      #0;
      settle(15);
      for (int o = 0; o < N; o++) begin
        automatic int src = (o - sh + N) % N;
        chk(rec_n[o] == 3, "R2 flit count", rec_n[o], 3);
        check_pkt(o, 0, src, o, 3, "R2 flit content");
      end
    end
    chk(out_valid == '0, "R7 idle outputs low", out_valid, 0);

    // R1/R5/R4: rotation from port 0 after reset, no interleaving
    do_reset();
    clear_rec();
    for (int s = 0; s < N; s++) begin
      automatic int ss = s;
      fork send_pkt(ss, 0, 3); join_none
    end
    #0;
    settle(80);
    chk(rec_n[0] == 30, "R5 contention count", rec_n[0], 30);
    for (int s = 0; s < N; s++) check_pkt(0, 3*s, s, 0, 3, "R5 R4 order and contiguity");

    // R5: pointer just past last winner (5 wins, then 8 before 2)
    clear_rec();
    send_pkt(5, 3, 2);
    settle(8);
    for (int s = 2; s <= 8; s += 6) begin
      automatic int ss = s;
      fork send_pkt(ss, 3, 2); join_none
    end
    #0;
    settle(20);
    chk(rec_n[3] == 6, "R5 wrap count", rec_n[3], 6);
    check_pkt(3, 0, 5, 3, 2, "R5 first winner");
    check_pkt(3, 2, 8, 3, 2, "R5 after pointer");
    check_pkt(3, 4, 2, 3, 2, "R5 wrap");

    // R6: invalid headers discarded
    clear_rec();
    send_pkt(4, 12, 3);
    send_pkt(4, 15, 1);
    send_pkt(4, 7, 2);
    settle(12);
    for (int o = 0; o < N; o++)
      chk(rec_n[o] == ((o == 7) ? 2 : 0), "R6 nothing of dropped packet", rec_n[o], (o == 7) ? 2 : 0);
    check_pkt(7, 0, 4, 7, 2, "R6 next packet delivered");

    // R3/R7: stall output 4, fill queue of input 6
    clear_rec();
    @(negedge clk); out_ready[4] = 1'b0;
    fork send_pkt(6, 4, 5); join_none
    repeat (12) @(negedge clk);
    #1;
    chk(in_ready[6] == 1'b0, "R3 queue full drops ready", in_ready[6], 0);
    chk(out_valid[4] == 1'b1, "R7 valid while stalled", out_valid[4], 1);
    chk(out_data[39:32] == 8'h64, "R7 header held", out_data[39:32], 8'h64);
    chk(rec_n[4] == 0, "R7 no transfer without ready", rec_n[4], 0);
    repeat (3) @(negedge clk);
    #1;
    chk(out_data[39:32] == 8'h64, "R7 header stable", out_data[39:32], 8'h64);
    @(negedge clk); out_ready[4] = 1'b1;
    settle(12);
    chk(rec_n[4] == 5, "R3 no loss under stall", rec_n[4], 5);
    check_pkt(4, 0, 6, 4, 5, "R3 order under stall");
    chk(in_ready == '1, "R3 ready restored", in_ready, 10'h3ff);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule